// File: doc/BRIEF.md
# Bit-Sliced Six-Operation ALU

This block is a 16-bit arithmetic and logic unit built from identical one-bit slices placed side by side. Each slice sees one bit of each operand, a link bit from the slice below it, and six operation enables. Each slice returns one result bit and a link bit for the slice above it. The link is the only connection between slices. It carries the ripple carry during addition and the neighbour's operand bit during a shift. No other lookahead or shift network is built at the top level.

The caller chooses the operation by raising one of six enable lines. There is no encoded opcode. When all six lines are low, the output is zero. The unit holds no state: the result and the flag follow the operands and the enables directly. The flag shows the carry out of the top bit for an addition, and the bit pushed out of the top for a shift.

Top module: `bitslice_alu`

## Requirements
- R1: With only `op_en[0]` high (AND), `result` equals the bitwise AND of `x` and `y`.
- R2: With only `op_en[1]` high (OR), `result` equals the bitwise OR of `x` and `y`.
- R3: With only `op_en[2]` high (XOR), `result` equals the bitwise XOR of `x` and `y`.
- R4: With only `op_en[3]` high (ADD), `result` equals `(x + y) mod 2^16`, with a carry of zero into bit 0.
- R5: During ADD, `carry_flag` equals the carry out of bit 15, which is bit 16 of the 17-bit sum `x + y`.
- R6: With only `op_en[4]` high (SHIFT), `result` equals `x` shifted left by one place. Bit 0 of `result` is zero.
- R7: During SHIFT, `carry_flag` equals `x[15]`.
- R8: With only `op_en[5]` high (NOT), `result` equals the bitwise inverse of `x`, and the value of `y` has no effect on `result`.
- R9: During AND, OR, XOR and NOT, `carry_flag` is zero.
- R10: With `op_en` all zero, both `result` and `carry_flag` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x | input | 16 | First operand; the only operand used by SHIFT and NOT |
| y | input | 16 | Second operand |
| op_en | input | 6 | One-hot operation enables: bit 0 AND, 1 OR, 2 XOR, 3 ADD, 4 SHIFT, 5 NOT |
| result | output | 16 | Result of the selected operation |
| carry_flag | output | 1 | Carry out of bit 15 for ADD, bit shifted out for SHIFT, zero otherwise |

## Verification
The unit has no registers, so every result and flag is due in the same cycle that its operands and enable are applied. There is no latency in cycles to account for. The bench applies a new operand pair and enable just after each rising edge. It compares `result` and `carry_flag` with its reference model at the following falling edge, once the ripple chain has had half a period to settle. Each vector is therefore checked in its own cycle, before the next vector replaces it. The vectors cover the corner values 0x0000, 0xFFFF and 0x8000, random operand pairs, and the all-zero enable.

// File: rtl/alu_pkg.sv
package alu_pkg;

    // Operation enable positions inside the one-hot select
    localparam int OP_W   = 6;
    localparam int OP_AND = 0;
    localparam int OP_OR  = 1;
    localparam int OP_XOR = 2;
    localparam int OP_ADD = 3;
    localparam int OP_SHL = 4;
    localparam int OP_NOT = 5;

    // Outputs of one bit slice
    typedef struct packed {
        logic res;
        logic link;
    } slice_out_t;

endpackage

// File: rtl/alu_slice.sv
module alu_slice
    import alu_pkg::*;
(
    input  logic            x_i,
    input  logic            y_i,
    input  logic            link_i,
    input  logic [OP_W-1:0] op_en_i,
    output logic            res_o,
    output logic            link_o
);

    slice_out_t out_d;
    logic       sum_bit;
    logic       gen_bit;
    logic       prop_bit;

    always_comb begin
        prop_bit = x_i ^ y_i;
        gen_bit  = x_i & y_i;
        sum_bit  = prop_bit ^ link_i;

        out_d.res = (op_en_i[OP_AND] & gen_bit)
                  | (op_en_i[OP_OR]  & (x_i | y_i))
                  | (op_en_i[OP_XOR] & prop_bit)
                  | (op_en_i[OP_ADD] & sum_bit)
                  | (op_en_i[OP_SHL] & link_i)
                  | (op_en_i[OP_NOT] & ~x_i);

        // link carries the ripple carry for ADD and the own x bit for SHIFT
        out_d.link = (op_en_i[OP_ADD] & (gen_bit | (link_i & prop_bit)))
                   | (op_en_i[OP_SHL] & x_i);
    end

    assign res_o  = out_d.res;
    assign link_o = out_d.link;

endmodule

// File: rtl/alu_chain.sv
module alu_chain
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x_i,
    input  logic [WIDTH-1:0] y_i,
    input  logic [OP_W-1:0]  op_en_i,
    output logic [WIDTH-1:0] res_o,
    output logic             link_o
);

    // link_w[i] enters slice i; link_w[WIDTH] leaves the top slice
    logic [WIDTH:0] link_w;

    assign link_w[0] = 1'b0;

    for (genvar i = 0; i < WIDTH; i++) begin : g_slice
        alu_slice u_slice (
            .x_i     (x_i[i]),
            .y_i     (y_i[i]),
            .link_i  (link_w[i]),
            .op_en_i (op_en_i),
            .res_o   (res_o[i]),
            .link_o  (link_w[i+1])
        );
    end

    assign link_o = link_w[WIDTH];

endmodule

// File: rtl/bitslice_alu.sv
module bitslice_alu
    import alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic [OP_W-1:0]  op_en,
    output logic [WIDTH-1:0] result,
    output logic             carry_flag
);

    localparam int SUM_W = WIDTH + 1;

    logic [WIDTH-1:0] chain_res;
    logic             chain_link;

    alu_chain #(.WIDTH(WIDTH)) u_chain (
        .x_i     (x),
        .y_i     (y),
        .op_en_i (op_en),
        .res_o   (chain_res),
        .link_o  (chain_link)
    );

    assign result     = chain_res;
    assign carry_flag = chain_link;

    logic [SUM_W-1:0] wide_sum;
    logic [SUM_W-1:0] wide_x;

    always_comb begin
        wide_sum = {1'b0, x} + {1'b0, y};
        wide_x   = {x, 1'b0};
        if (op_en == '0) begin
            // R10
            no_op_zero_chk: assert (result == '0 && carry_flag == 1'b0)
                else $error("idle select gave nonzero output");
        end
        if (op_en == (OP_W'(1) << OP_ADD)) begin
            // R5
            add_carry_chk: assert ({carry_flag, result} == wide_sum)
                else $error("ripple sum mismatch");
        end
        if (op_en == (OP_W'(1) << OP_SHL)) begin
            // R7
            shift_out_chk: assert ({carry_flag, result} == wide_x)
                else $error("shift mismatch");
        end
        if (op_en == (OP_W'(1) << OP_NOT)) begin
            // R8
            invert_chk: assert (result == ~x)
                else $error("invert mismatch");
        end
        if (op_en[OP_AND] | op_en[OP_OR] | op_en[OP_XOR] | op_en[OP_NOT]) begin
            // R9
            logic_flag_low_chk: assert (carry_flag == 1'b0)
                else $error("flag raised by logic operation");
        end
    end

endmodule

// File: tb/bitslice_alu_tb_top.sv
module bitslice_alu_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [W-1:0] x = '0;
    logic [W-1:0] y = '0;
    logic [5:0]   op_en = '0;
    logic [W-1:0] result;
    logic         carry_flag;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    bitslice_alu #(.WIDTH(W)) dut_i (
        .x          (x),
        .y          (y),
        .op_en      (op_en),
        .result     (result),
        .carry_flag (carry_flag)
    );

    // Behavioural reference: returns {flag, result}
    function automatic logic [W:0] model(input logic [W-1:0] a,
                                         input logic [W-1:0] b,
                                         input logic [5:0]   sel);
        int unsigned s;
        case (sel)
            6'b000001: return {1'b0, a & b};
            6'b000010: return {1'b0, a | b};
            6'b000100: return {1'b0, a ^ b};
            6'b001000: begin
                s = int'(a) + int'(b);
                return s[W:0];
            end
            6'b010000: return {a, 1'b0};
            6'b100000: return {1'b0, ~a};
            default:   return '0;
        endcase
    endfunction

    function automatic string res_tag(input logic [5:0] sel);
        case (sel)
            6'b000001: return "R1";
            6'b000010: return "R2";
            6'b000100: return "R3";
            6'b001000: return "R4";
            6'b010000: return "R6";
            6'b100000: return "R8";
            default:   return "R10";
        endcase
    endfunction

    function automatic string flag_tag(input logic [5:0] sel);
        case (sel)
            6'b001000: return "R5";
            6'b010000: return "R7";
            6'b000000: return "R10";
            default:   return "R9";
        endcase
    endfunction

    task automatic check_now();
        logic [W:0] exp;
        exp = model(x, y, op_en);
        total++;
        if (result !== exp[W-1:0]) begin
            bad++;
            $display("FAIL %s result x=%h y=%h op=%b actual=%h expected=%h",
                     res_tag(op_en), x, y, op_en, result, exp[W-1:0]);
        end
        total++;
        if (carry_flag !== exp[W]) begin
            bad++;
            $display("FAIL %s flag x=%h y=%h op=%b actual=%b expected=%b",
                     flag_tag(op_en), x, y, op_en, carry_flag, exp[W]);
        end
    endtask

    // Apply just after a rising edge, check at the following falling edge
    task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b,
                         input logic [5:0] sel);
        @(posedge clk);
        x     <= a;
        y     <= b;
        op_en <= sel;
        @(negedge clk);
        check_now();
    endtask

    localparam logic [W-1:0] CORNER [3] = '{16'h0000, 16'hFFFF, 16'h8000};

    initial begin
        // reset state: idle select, outputs zero (R10)
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_now();
        rst = 1'b0;

        for (int k = 0; k < 6; k++) begin
            for (int i = 0; i < 3; i++) begin
                for (int j = 0; j < 3; j++) begin
                    apply(CORNER[i], CORNER[j], 6'(1) << k);
                end
            end
        end

        // R4 R5 ripple through every bit; R6 R7 top bit out
        apply(16'hFFFF, 16'h0001, 6'b001000);
        apply(16'h7FFF, 16'h0001, 6'b001000);
        apply(16'hC001, 16'h0000, 6'b010000);
        // R8: y has no effect on NOT
        apply(16'h1234, 16'h0000, 6'b100000);
        apply(16'h1234, 16'hFFFF, 6'b100000);
        // R10: idle select with busy operands
        apply(16'hFFFF, 16'hFFFF, 6'b000000);

        for (int n = 0; n < 600; n++) begin
            apply(W'($urandom), W'($urandom), 6'(1) << (n % 6));
        end
        for (int n = 0; n < 20; n++) begin
            apply(W'($urandom), W'($urandom), 6'b000000);
        end

        done = 1'b1;
    end

    initial begin : watchdog
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule